// File: doc/BRIEF.md
# Five-Channel Timer Tick Generator

This block turns one peripheral clock into five count-enable strobes for a bank of timer channels. Two 8-bit prescalers divide the input clock. The first prescaler serves channels 0 and 1, and the second serves channels 2, 3 and 4. Each channel then passes its prescaler's strobe through its own power-of-two divider. The result is one single-cycle tick per channel per divided period. A downstream timer counter uses that tick as its enable.

Two configuration words set the behaviour. Word 0 holds both prescaler values. Word 1 holds a 4-bit divider code for every channel. Software changes one field with a read-modify-write cycle: it reads a word back, patches the field and writes the whole word again. A field whose value is written unchanged must therefore leave its channels running without a glitch. A prescaler or code that really changes restarts the affected counters from zero.

Each prescaler runs a two-state machine. It enters the state `PS_RESTART` on reset or on a change of its value, and there it holds its counter at zero and gives no strobe. From `PS_RESTART` it always moves to `PS_COUNT` on the next cycle. In `PS_COUNT` it counts from 0 up to the stored value, strobes on the terminal count and wraps to zero. A change of the value sends it back to `PS_RESTART` from either state.

Top module: `tmr_tick_gen`

## Requirements
- R1: While reset is asserted, both configuration words read back as zero and every tick output is low.
- R2: Word 0 carries prescaler 0 in bits [7:0], which serves channels 0 and 1, and prescaler 1 in bits [15:8], which serves channels 2 to 4. Bits [31:16] of word 0 are not stored and read back as zero.
- R3: Word 1 carries the divider code of channel c in bits [4c+3:4c], for c from 0 to 4. Bits [31:20] of word 1 are not stored and read back as zero.
- R4: With a stored prescaler value N and a divider code s, a channel ticks once every (N+1)×2^(s+DIV_BASE) input clock cycles.
- R5: A code for which s+DIV_BASE exceeds 4 divides by 16.
- R6: Every tick is high for exactly one input clock cycle per period.
- R7: A write in cycle W that changes a prescaler value restarts that prescaler and every divider it serves. Those channels give no tick in cycles W+1 to W+1+P and tick first in cycle W+2+P, where P is the new period.
- R8: A write that leaves a field unchanged does not disturb the tick phase of the channels that field serves. This holds whether the write goes to the other word or rewrites the same value.
- R9: A write that changes only the divider code of a channel restarts that channel's divider. The channel gives no tick in the cycle after the write and afterwards ticks with the new period.
- R10: With DIV_BASE set to 1, code 0 divides by 2 and every code divides by twice the divisor it selects when DIV_BASE is 0, up to the limit of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all counters divide |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the selected word in this cycle |
| wr_sel | input | 1 | Word selected for the write: 0 for the prescaler word, 1 for the divider code word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Word selected for readback |
| rd_data | output | 32 | Current contents of the selected word, zero-extended |
| tick_o | output | 5 | Tick strobe for each channel; bit c belongs to channel c |

## Verification
The bench sweeps all 16 divider codes across every channel under several prescaler pairs. It runs this sweep on two instances, one with divider base 0 and one with base 1. From each restart it checks every cycle against the period it computes arithmetically. A divider that did not saturate would produce periods of 32 and more. A design that ignored the base would give the base-1 instance the same periods as the base-0 one. A design that let a tick through in the cycle after a write, or that started counting one cycle early or late, would miss the exact first-tick cycle.

Other checks cover the read-modify-write cases. When a write leaves a prescaler unchanged, or changes only one channel's code, the bench verifies that the untouched channels stay on their old grid. A design that restarted on every write, or on every write to a word, would knock those channels off their grid. The bench also checks that the patched channel takes up its new period.

// File: rtl/tkg_pkg.sv
`timescale 1ns/1ps
package tkg_pkg;

    // Prescaler sequencing states
    typedef enum logic {
        PS_RESTART = 1'b0,
        PS_COUNT   = 1'b1
    } ps_state_e;

    // log2 of the divisor for a select code, saturated at cap
    function automatic int div_log2(input int code, input int base, input int cap);
        int sum;
        sum = code + base;
        return (sum > cap) ? cap : sum;
    endfunction

endpackage

// File: rtl/tkg_cfg_regs.sv
`timescale 1ns/1ps
module tkg_cfg_regs #(
    parameter int NUM_CH = 5,
    parameter int NUM_PS = 2,
    parameter int PRE_W  = 8,
    parameter int SEL_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_sel,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic                              rd_sel,
    output logic [WORD_W-1:0]                 rd_data,
    output logic [NUM_PS-1:0][PRE_W-1:0]      pre_val,
    output logic [NUM_CH-1:0][SEL_W-1:0]      sel_val,
    output logic [NUM_PS-1:0]                 pre_chg,
    output logic [NUM_CH-1:0]                 sel_chg
);
    localparam int PRE_BITS = NUM_PS * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;
    localparam int USED_W   = (PRE_BITS > SEL_BITS) ? PRE_BITS : SEL_BITS;

    logic [NUM_PS-1:0][PRE_W-1:0] pre_q;
    logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
    logic [NUM_PS-1:0][PRE_W-1:0] pre_new;
    logic [NUM_CH-1:0][SEL_W-1:0] sel_new;
    logic                         wr_pre;
    logic                         wr_div;

    assign wr_pre  = wr_en && !wr_sel;
    assign wr_div  = wr_en &&  wr_sel;
    assign pre_new = wr_data[PRE_BITS-1:0];
    assign sel_new = wr_data[SEL_BITS-1:0];

    generate
        if (WORD_W > USED_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^wr_data[WORD_W-1:USED_W];
        end
    endgenerate

    // Per-field change detection: only a real change restarts counters
    always_comb begin
        for (int g = 0; g < NUM_PS; g++) begin
            pre_chg[g] = wr_pre && (pre_new[g] != pre_q[g]);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            sel_chg[c] = wr_div && (sel_new[c] != sel_q[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sel_q <= '0;
        end else begin
            if (wr_pre) pre_q <= pre_new;
            if (wr_div) sel_q <= sel_new;
        end
    end

    assign pre_val = pre_q;
    assign sel_val = sel_q;
    assign rd_data = rd_sel ? {{(WORD_W-SEL_BITS){1'b0}}, sel_q}
                            : {{(WORD_W-PRE_BITS){1'b0}}, pre_q};

    // R8: a word is only altered by a write addressed to it
    a_r8_pre_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pre |=> $stable(pre_q));
    a_r8_sel_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_div |=> $stable(sel_q));

endmodule

// File: rtl/tkg_prescaler.sv
`timescale 1ns/1ps
module tkg_prescaler
    import tkg_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             restart,
    output logic             pre_tick
);
    ps_state_e        state_q;
    ps_state_e        state_d;
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RESTART;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        pre_tick = 1'b0;
        unique case (state_q)
            PS_RESTART: begin
                cnt_d   = '0;
                state_d = PS_COUNT;
            end
            PS_COUNT: begin
                pre_tick = (cnt_q == pre_val);
                cnt_d    = pre_tick ? '0 : cnt_q + 1'b1;
            end
            default: begin
                state_d = PS_RESTART;
            end
        endcase
        if (restart) begin
            state_d = PS_RESTART;
            cnt_d   = '0;
        end
    end

    // R7: the cycle after a restart carries no strobe
    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pre_tick);
    // R4: the counter never passes the stored value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_COUNT) |-> (cnt_q <= pre_val));
    // R6: a strobe is isolated unless the prescaler divides by one
    a_r6_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && (pre_val != '0)) |=> !pre_tick);

endmodule

// File: rtl/tkg_divider.sv
`timescale 1ns/1ps
module tkg_divider
    import tkg_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int LOG_MAX  = 4,
    parameter int DIV_BASE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    int                 lg;
    logic [LOG_MAX-1:0] mask;
    logic [LOG_MAX-1:0] cnt_q;
    logic               fire;
    logic               tick_q;

    // Decode the code into a low-bit mask of width log2(divisor)
    always_comb begin
        lg = div_log2(32'(sel), DIV_BASE, LOG_MAX);
        for (int b = 0; b < LOG_MAX; b++) begin
            mask[b] = (b < lg);
        end
    end

    assign fire = pre_tick && ((cnt_q | ~mask) == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            if (restart)       cnt_q <= '0;
            else if (pre_tick) cnt_q <= cnt_q + 1'b1;
            tick_q <= fire && !restart;
        end
    end

    assign tick = tick_q;

    // R7 / R9: a restart suppresses the tick of the following cycle
    a_r9_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick_q);
    // R4: every tick is caused by a prescaler strobe
    a_r4_tick_from_pre: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(pre_tick));
    // R6: single-cycle tick whenever the divider divides by more than one
    a_r6_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && (mask != '0)) |=> !tick_q);

endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen #(
    parameter int NUM_CH   = 5,
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 4,
    parameter int WORD_W   = 32,
    parameter int GRP0_CH  = 2,
    parameter int LOG_MAX  = 4,
    parameter int DIV_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_CH-1:0] tick_o
);
    localparam int NUM_PS = 2;

    logic [NUM_PS-1:0][PRE_W-1:0] pre_val;
    logic [NUM_CH-1:0][SEL_W-1:0] sel_val;
    logic [NUM_PS-1:0]            pre_chg;
    logic [NUM_CH-1:0]            sel_chg;
    logic [NUM_PS-1:0]            pre_tick;

    tkg_cfg_regs #(
        .NUM_CH (NUM_CH),
        .NUM_PS (NUM_PS),
        .PRE_W  (PRE_W),
        .SEL_W  (SEL_W),
        .WORD_W (WORD_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .pre_val (pre_val),
        .sel_val (sel_val),
        .pre_chg (pre_chg),
        .sel_chg (sel_chg)
    );

    generate
        for (genvar g = 0; g < NUM_PS; g++) begin : g_ps
            tkg_prescaler #(.PRE_W(PRE_W)) u_ps (
                .clk      (clk),
                .rst_n    (rst_n),
                .pre_val  (pre_val[g]),
                .restart  (pre_chg[g]),
                .pre_tick (pre_tick[g])
            );
        end

        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int GRP = (c < GRP0_CH) ? 0 : 1;
            tkg_divider #(
                .SEL_W    (SEL_W),
                .LOG_MAX  (LOG_MAX),
                .DIV_BASE (DIV_BASE)
            ) u_div (
                .clk      (clk),
                .rst_n    (rst_n),
                .pre_tick (pre_tick[GRP]),
                .sel      (sel_val[c]),
                .restart  (pre_chg[GRP] | sel_chg[c]),
                .tick     (tick_o[c])
            );
        end
    endgenerate

endmodule

// File: tb/sim_tmr_tick_gen.sv
`timescale 1ns/1ps
module sim_tmr_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic        rd_sel;
    logic [31:0] rd0;
    logic [31:0] rd1;
    logic [4:0]  tk0;
    logic [4:0]  tk1;
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [4:0]  rec0 [300];
    logic [4:0]  rec1 [300];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_tick_gen #(.DIV_BASE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd0), .tick_o(tk0));
    tmr_tick_gen #(.DIV_BASE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd1), .tick_o(tk1));

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int dlog(input int s, input int base);
        return (s + base > 4) ? 4 : s + base;
    endfunction

    function automatic int per(input int n, input int s, input int base);
        return (n + 1) * (1 << dlog(s, base));
    endfunction

    function automatic bit on_grid(input int t, input int w, input int p);
        return (t >= w + 2 + p) && (((t - w - 2) % p) == 0);
    endfunction

    // Called at a falling edge; the write happens in the current cycle w
    task automatic wr(input logic s, input logic [31:0] d, output int w);
        wr_sel  = s;
        wr_data = d;
        wr_en   = 1'b1;
        w       = cyc;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [31:0] sel_word(input int sb);
        logic [31:0] v = '0;
        for (int c = 0; c < 5; c++) v[4*c +: 4] = 4'((sb + c) % 16);
        return v;
    endfunction

    // Configure, force a restart of both prescalers and check every cycle
    task automatic sweep_one(input int n0, input int n1, input int sb, output int w);
        int dmy;
        wr(1'b1, sel_word(sb), dmy);
        wr(1'b0, {16'h0, 8'(n1 + 100), 8'(n0 + 100)}, dmy);
        wr(1'b0, {16'h0, 8'(n1), 8'(n0)}, w);
        for (int i = 0; i < 300; i++) begin
            rec0[i] = tk0;
            rec1[i] = tk1;
            @(negedge clk);
        end
        for (int inst = 0; inst < 2; inst++) begin
            for (int c = 0; c < 5; c++) begin
                int  n     = (c < 2) ? n0 : n1;
                int  s     = (sb + c) % 16;
                int  p     = per(n, s, inst);
                int  fb    = -1;
                int  nt    = 0;
                bit  a     = 0;
                bit  e     = 0;
                string tg;
                for (int i = 0; i <= 3 * p + 1; i++) begin
                    bit act = inst ? rec1[i][c] : rec0[i][c];
                    bit exv = (i >= 1 + p) && (((i - 1) % p) == 0);
                    if (act) nt++;
                    if (act != exv && fb < 0) begin
                        fb = i; a = act; e = exv;
                    end
                end
                if (fb >= 0 && fb <= 1 + p) tg = "R7";
                else if (s + inst > 4)      tg = "R5";
                else if (inst == 1)         tg = "R10";
                else                        tg = "R4";
                chk(fb < 0, tg, $sformatf("inst=%0d ch=%0d n=%0d code=%0d off=%0d tick",
                    inst, c, n, s, fb), longint'(a), longint'(e));
                chk(nt == 3, "R6", $sformatf("inst=%0d ch=%0d tick count in 3 periods",
                    inst, c), nt, 3);
            end
        end
    endtask

    initial begin
        int w, w2, w3, dmy;
        int p_old [5];
        int mis [5];
        int t4 [$];
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = '0;
        rd_sel  = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk(rd0 == 32'h0, "R1", "word0 in reset", rd0, 0);
        chk(tk0 == 5'h0 && tk1 == 5'h0, "R1", "ticks in reset", {tk1, tk0}, 0);
        rd_sel = 1'b1;
        @(negedge clk);
        chk(rd0 == 32'h0, "R1", "word1 in reset", rd0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: field layout and readback
        wr(1'b0, 32'hDEAD_1234, dmy);
        rd_sel = 1'b0;
        @(negedge clk);
        chk(rd0 == 32'h0000_1234, "R2", "word0 readback", rd0, 32'h1234);
        wr(1'b1, 32'hFFFF_FFFF, dmy);
        rd_sel = 1'b1;
        @(negedge clk);
        chk(rd0 == 32'h000F_FFFF, "R3", "word1 readback", rd0, 32'hF_FFFF);
        rd_sel = 1'b0;
        @(negedge clk);
        chk(rd0 == 32'h0000_1234, "R8", "word0 after word1 write", rd0, 32'h1234);

        // R4 R5 R6 R7 R10: sweep all codes on every channel
        for (int np = 0; np < 4; np++) begin
            int na = (np == 0) ? 0 : (np == 1) ? 1 : (np == 2) ? 2 : 5;
            int nb = (np == 0) ? 2 : (np == 1) ? 0 : (np == 2) ? 5 : 1;
            for (int sb = 0; sb < 16; sb++) sweep_one(na, nb, sb, w);
        end

        // R8 / R9: phase preservation under read-modify-write
        sweep_one(1, 2, 1, w);
        for (int c = 0; c < 5; c++) p_old[c] = per((c < 2) ? 1 : 2, (1 + c) % 16, 0);
        wr(1'b1, sel_word(1) & 32'hFFF0_FFFF, w2);
        for (int c = 0; c < 5; c++) mis[c] = 0;
        chk(tk0[4] == 1'b0, "R9", "ch4 tick after code change", tk0[4], 0);
        for (int j = 0; j < 200; j++) begin
            for (int c = 0; c < 4; c++)
                if (tk0[c] != on_grid(cyc, w, p_old[c])) mis[c]++;
            if (tk0[4]) t4.push_back(cyc);
            @(negedge clk);
        end
        for (int c = 0; c < 4; c++)
            chk(mis[c] == 0, "R8", $sformatf("ch%0d phase after ch4 code write", c), mis[c], 0);
        chk(t4.size() >= 3, "R9", "ch4 ticks after code change", t4.size(), 3);
        for (int k = 1; k < t4.size(); k++)
            chk(t4[k] - t4[k-1] == 3, "R9", "ch4 new period", t4[k] - t4[k-1], 3);

        wr(1'b0, {16'h0, 8'd4, 8'd1}, w3);
        for (int c = 0; c < 5; c++) mis[c] = 0;
        for (int j = 0; j < 200; j++) begin
            for (int c = 0; c < 2; c++)
                if (tk0[c] != on_grid(cyc, w, p_old[c])) mis[c]++;
            if (tk0[2] != on_grid(cyc, w3, 40)) mis[2]++;
            if (tk0[3] != on_grid(cyc, w3, 80)) mis[3]++;
            if (tk0[4] != on_grid(cyc, w3, 5))  mis[4]++;
            @(negedge clk);
        end
        for (int c = 0; c < 2; c++)
            chk(mis[c] == 0, "R8", $sformatf("ch%0d phase with prescaler0 rewritten", c), mis[c], 0);
        for (int c = 2; c < 5; c++)
            chk(mis[c] == 0, "R7", $sformatf("ch%0d restart after prescaler1 change", c), mis[c], 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(negedge clk) begin
        if (!done && cyc > 150000) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog all act=%0d exp<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule